// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM Core

This block is a synthesizable single-clock model of a pipelined synchronous static RAM. Each word is 36 bits wide and is split into four 9-bit byte lanes. All address, data and control inputs are captured on the rising clock edge. A new access starts when one of two address strobes is asserted. The processor strobe always starts a read. The controller strobe starts a read or a write, depending on the write controls. Once a burst has started, an advance input steps a 2-bit counter that walks the other words of the aligned four-word group. When the advance input is idle, the same word is accessed again.

Read data passes through the captured-input stage and then an output register. Output drive is controlled by a pipelined enable. After a deselect, that enable keeps the drivers on for one extra cycle, so several devices can share one data bus with no turnaround wait state. The output-enable pin gates the drive combinationally. The shared bidirectional bus is modelled as separate input, output and drive-enable ports. The word count is set by the address-width parameter: 15 bits gives 32K words, and the default is kept smaller for quick elaboration.

Top module: `sync_burst_sram`

## Requirements
- R1: After synchronous reset, `dout_oe` is 0 and `dout` is 0. No burst is active, so cycles with no strobe leave the drive off.
- R2: A strobe start (processor strobe with `ce1_n` low, or controller strobe) while the device is not selected is a deselect. Selected means `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A deselect ends the burst and does not change `dout`, and later cycles with no strobe start nothing.
- R3: A selected controller-strobe start is a write when `gw_n`=0, or when `bw_en_n`=0 with any `lane_we_n` bit low. Lane i is bits 9i+8..9i and is written when `lane_we_n[i]`=0 and `bw_en_n`=0. With `bw_en_n`=1 no lane is written. The data is taken at the same edge as the address.
- R4: `gw_n`=0 writes all four lanes, whatever `bw_en_n` and `lane_we_n` are.
- R5: A processor-strobe start is always a read, even when write controls are active. The processor strobe is ignored while `ce1_n`=1, and the cycle is then decoded as if that strobe were absent.
- R6: Read data for an access captured at edge k is on `dout`, with `dout_oe`=1 (when `oe_n`=0), after edge k+1.
- R7: With `burst_ilv`=0, each cycle with no strobe and `adv_n`=0 advances the access to the word whose two low address bits are (start low bits + n) mod 4. The upper address bits do not change. Writes in such cycles follow the same sequence.
- R8: With `burst_ilv`=1, the two low address bits of the n-th word are (start low bits XOR n).
- R9: A cycle with no strobe and `adv_n`=1 during an active burst accesses the same word again.
- R10: When a read at edge k is followed by a deselect at edge k+1, `dout_oe` stays 1 with the read data held after edge k+2, and drops to 0 after edge k+3.
- R11: `oe_n`=1 forces `dout_oe` to 0 at once, without waiting for a clock edge, and releasing it restores the drive at once.
- R12: For a write captured at edge k, `dout_oe` is 0 after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW | Word address |
| din | input | 36 | Write data |
| ce1_n | input | 1 | Active-low chip enable; also qualifies the processor strobe |
| ce2 | input | 1 | Active-high chip enable |
| ce3_n | input | 1 | Active-low chip enable |
| strb_p_n | input | 1 | Processor address strobe, active low |
| strb_c_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| lane_we_n | input | 4 | Per-lane write enables, active low |
| bw_en_n | input | 1 | Qualifier for the lane enables, active low |
| gw_n | input | 1 | Global all-lane write, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_ilv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| dout | output | 36 | Read data from the output register |
| dout_oe | output | 1 | Bus drive enable |

## Verification
If the burst counter or the captured base address holds a wrong value, the next read returns another word's data two edges after the faulty step. A lost write only shows when that word is read back, so every write is checked by a later read. A fault in the drive-enable pipeline shows in `dout_oe` one edge after the stage goes wrong: drive stays on after a write, the extra cycle after a deselect is missing, or the drive never turns off. Stale output-register contents show as `dout` changing during a deselect.

// File: rtl/sbs_pkg.sv
// Shared types and constants for the pipelined burst SRAM.
// Assumes a fixed 36-bit word made of four 9-bit lanes.
package sbs_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    // Operation carried down the pipeline; IDLE also stands for deselect.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } sbs_op_t;

    // Low address bits of the n-th burst beat.
    function automatic logic [1:0] beat_low(input logic [1:0] start,
                                            input logic [1:0] n,
                                            input logic       ilv);
        return ilv ? (start ^ n) : (start + n);
    endfunction
endpackage

// File: rtl/sbs_in_stage.sv
// Input stage: decodes strobes, chip enables and write controls, and
// registers the resulting operation, lane mask and write data.
// Assumes the burst unit supplies whether a burst is active.
module sbs_in_stage
    import sbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] din,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              strb_p_n,
    input  logic              strb_c_n,
    input  logic              adv_n,
    input  logic [LANES-1:0]  lane_we_n,
    input  logic              bw_en_n,
    input  logic              gw_n,
    input  logic              active,
    output logic              load,
    output logic              kill,
    output logic              step,
    output sbs_op_t           op_q,
    output logic [LANES-1:0]  lanes_q,
    output logic [WORD_W-1:0] din_q
);
    logic             sel;
    logic             p_go;
    logic             c_go;
    logic             start;
    logic [LANES-1:0] lanes_n;
    logic             wr;
    sbs_op_t          op_n;

    // Decode this cycle's pins into a command for the next stage.
    always_comb begin
        sel     = !ce1_n && ce2 && !ce3_n;
        p_go    = !strb_p_n && !ce1_n;
        c_go    = !strb_c_n && !p_go;
        start   = p_go || c_go;
        if (!gw_n)
            lanes_n = '1;
        else if (!bw_en_n)
            lanes_n = ~lane_we_n;
        else
            lanes_n = '0;
        wr   = |lanes_n;
        load = start && sel;
        kill = start && !sel;
        step = !start && active && !adv_n;
        if (load)
            op_n = (c_go && wr) ? OP_WRITE : OP_READ;
        else if (kill || !active)
            op_n = OP_IDLE;
        else
            op_n = wr ? OP_WRITE : OP_READ;
    end

    // Capture the decoded command and write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_IDLE;
            lanes_q <= '0;
            din_q   <= '0;
        end else begin
            op_q    <= op_n;
            lanes_q <= lanes_n;
            din_q   <= din;
        end
    end
endmodule

// File: rtl/sbs_burst_addr.sv
// Burst address unit: holds the start address, the 2-bit beat counter
// and the burst-active flag, and forms the current word address.
// Assumes AW >= 3 so that a four-word group fits.
module sbs_burst_addr
    import sbs_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          load,
    input  logic          kill,
    input  logic          step,
    input  logic          ilv,
    output logic          active,
    output logic [AW-1:0] cur_addr
);
    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;

    // Load on a selected start, stop on deselect, count on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            active <= 1'b0;
        end else if (load) begin
            base_q <= addr;
            cnt_q  <= '0;
            active <= 1'b1;
        end else if (kill) begin
            active <= 1'b0;
        end else if (step) begin
            cnt_q  <= cnt_q + 2'd1;
        end
    end

    // Current address wraps inside the aligned four-word group.
    always_comb begin
        cur_addr = {base_q[AW-1:2], beat_low(base_q[1:0], cnt_q, ilv)};
    end
endmodule

// File: rtl/sbs_array.sv
// Word array with per-lane write strobes and combinational read.
// Assumes one access per cycle, given by the input stage.
module sbs_array
    import sbs_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic              clk,
    input  sbs_op_t           op,
    input  logic [AW-1:0]     addr,
    input  logic [LANES-1:0]  lanes,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [WORD_W-1:0] mem [DEPTH];

    // Write the selected lanes of the addressed word.
    always_ff @(posedge clk) begin
        if (op == OP_WRITE) begin
            for (int i = 0; i < LANES; i++) begin
                if (lanes[i])
                    mem[addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
            end
        end
    end

    // Present the addressed word to the output register.
    always_comb begin
        rdata = mem[addr];
    end
endmodule

// File: rtl/sbs_out_pipe.sv
// Output stage: output data register plus the pipelined drive enable.
// The drive stays on one extra cycle after a deselect.
// Assumes IDLE in the pipeline marks a deselect or an empty cycle.
module sbs_out_pipe
    import sbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  sbs_op_t           op1,
    input  logic [WORD_W-1:0] rdata,
    input  logic              oe_n,
    output logic [WORD_W-1:0] dout,
    output logic              dout_oe
);
    sbs_op_t op2_q;
    logic    drv_q;

    // Load read data, and keep the drive on through one deselect cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op2_q <= OP_IDLE;
            drv_q <= 1'b0;
            dout  <= '0;
        end else begin
            op2_q <= op1;
            drv_q <= (op1 == OP_READ) || (op1 == OP_IDLE && op2_q == OP_READ);
            if (op1 == OP_READ)
                dout <= rdata;
        end
    end

    // Output enable gates the drive without a clock.
    always_comb begin
        dout_oe = !oe_n && drv_q;
    end
endmodule

// File: rtl/sync_burst_sram.sv
// Top of the pipelined burst SRAM: input stage, burst address unit,
// array and output stage. Assumes a single clock domain and that
// burst_ilv is changed only while no burst is in progress.
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] din,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              strb_p_n,
    input  logic              strb_c_n,
    input  logic              adv_n,
    input  logic [LANES-1:0]  lane_we_n,
    input  logic              bw_en_n,
    input  logic              gw_n,
    input  logic              oe_n,
    input  logic              burst_ilv,
    output logic [WORD_W-1:0] dout,
    output logic              dout_oe
);
    logic              load;
    logic              kill;
    logic              step;
    logic              active;
    sbs_op_t           op1;
    logic [LANES-1:0]  lanes1;
    logic [WORD_W-1:0] din1;
    logic [AW-1:0]     cur_addr;
    logic [WORD_W-1:0] rdata;

    sbs_in_stage u_in (
        .clk(clk), .rst_n(rst_n), .din(din),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .strb_p_n(strb_p_n), .strb_c_n(strb_c_n), .adv_n(adv_n),
        .lane_we_n(lane_we_n), .bw_en_n(bw_en_n), .gw_n(gw_n),
        .active(active), .load(load), .kill(kill), .step(step),
        .op_q(op1), .lanes_q(lanes1), .din_q(din1)
    );

    sbs_burst_addr #(.AW(AW)) u_burst (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .load(load), .kill(kill), .step(step), .ilv(burst_ilv),
        .active(active), .cur_addr(cur_addr)
    );

    sbs_array #(.AW(AW)) u_mem (
        .clk(clk), .op(op1), .addr(cur_addr), .lanes(lanes1),
        .wdata(din1), .rdata(rdata)
    );

    sbs_out_pipe u_out (
        .clk(clk), .rst_n(rst_n), .op1(op1), .rdata(rdata),
        .oe_n(oe_n), .dout(dout), .dout_oe(dout_oe)
    );
endmodule

// File: rtl/sbs_checker.sv
// Port-level protocol checks for the burst SRAM, bound to the top.
module sbs_checker #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce1_n,
    input logic          ce2,
    input logic          ce3_n,
    input logic          strb_p_n,
    input logic          strb_c_n,
    input logic          gw_n,
    input logic          oe_n,
    input logic [35:0]   dout,
    input logic          dout_oe
);
    logic sel;
    logic rd_go;
    logic ds_go;
    logic wr_go;

    // Classify this cycle's pins as read start, deselect or global write.
    always_comb begin
        sel   = !ce1_n && ce2 && !ce3_n;
        rd_go = !strb_p_n && !ce1_n && sel;
        ds_go = !strb_c_n && strb_p_n && !sel;
        wr_go = !strb_c_n && strb_p_n && sel && !gw_n;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !dout_oe);

    // R12
    write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> ##1 !dout_oe);

    // R6
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> ##1 (oe_n || dout_oe));

    // R10
    dcd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go ##1 ds_go |=> ##1 (oe_n || dout_oe));

    // R10
    dcd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go ##1 ds_go ##1 (strb_p_n && strb_c_n) |=> ##1 !dout_oe);

    // R2
    desel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ds_go |=> ##1 $stable(dout));
endmodule

bind sync_burst_sram sbs_checker #(.AW(AW)) i_sbs_chk (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .strb_p_n(strb_p_n), .strb_c_n(strb_c_n), .gw_n(gw_n), .oe_n(oe_n),
    .dout(dout), .dout_oe(dout_oe)
);

// File: tb/test_sync_burst_sram.sv
`timescale 1ns/1ps
module test_sync_burst_sram;
    localparam int AW = 6;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [35:0]   din = '0;
    logic          ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
    logic          strb_p_n = 1'b1, strb_c_n = 1'b1, adv_n = 1'b1;
    logic [3:0]    lane_we_n = 4'hF;
    logic          bw_en_n = 1'b1, gw_n = 1'b1, oe_n = 1'b0, burst_ilv = 1'b0;
    logic [35:0]   dout;
    logic          dout_oe;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sync_burst_sram #(.AW(AW)) i_sync_burst_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .strb_p_n(strb_p_n), .strb_c_n(strb_c_n), .adv_n(adv_n),
        .lane_we_n(lane_we_n), .bw_en_n(bw_en_n), .gw_n(gw_n),
        .oe_n(oe_n), .burst_ilv(burst_ilv), .dout(dout), .dout_oe(dout_oe)
    );

    function automatic logic [35:0] pat(input int a, input int s);
        return {4'(s), 8'(a), 12'(a * 7 + s), 12'(a ^ (s << 3))};
    endfunction

    function automatic logic [35:0] merge(input logic [35:0] o, input logic [35:0] nw,
                                          input logic [3:0] m);
        logic [35:0] r = o;
        for (int i = 0; i < 4; i++)
            if (m[i]) r[i*9 +: 9] = nw[i*9 +: 9];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [35:0] act,
                       input logic [35:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_pins();
        strb_p_n = 1'b1; strb_c_n = 1'b1; adv_n = 1'b1;
        gw_n = 1'b1; bw_en_n = 1'b1; lane_we_n = 4'hF;
        ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    endtask

    // Single write via the controller strobe; returns drive after edge k+1.
    task automatic wr_word(input int a, input logic [35:0] d, input logic g,
                           input logic b, input logic [3:0] l, output logic oe_after);
        @(negedge clk);
        addr = AW'(a); din = d; strb_c_n = 1'b0; gw_n = g; bw_en_n = b; lane_we_n = l;
        @(negedge clk);
        idle_pins();
        @(negedge clk);
        oe_after = dout_oe;
    endtask

    // Single read via the processor strobe; samples after edge k+1.
    task automatic rd_word(input int a, output logic [35:0] d, output logic oe);
        @(negedge clk);
        addr = AW'(a); strb_p_n = 1'b0;
        @(negedge clk);
        strb_p_n = 1'b1;
        @(negedge clk);
        d = dout; oe = dout_oe;
    endtask

    task automatic deselect_now();
        @(negedge clk);
        strb_c_n = 1'b0; ce2 = 1'b0;
        @(negedge clk);
        idle_pins();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog actual=%h expected=%h", 36'd0, 36'd1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [35:0] d;
        logic        oe;
        logic [35:0] exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: quiet after reset
        chk(dout_oe == 1'b0, "R1 oe", 36'(dout_oe), 36'd0);
        chk(dout == '0, "R1 dout", dout, 36'd0);

        // R4, R12: fill every word with global writes
        for (int a = 0; a < NW; a++) begin
            wr_word(a, pat(a, 0), 1'b0, 1'b1, 4'hF, oe);
            chk(oe == 1'b0, "R12 write drive", 36'(oe), 36'd0);
        end
        // R6: read back every word
        for (int a = 0; a < NW; a++) begin
            rd_word(a, d, oe);
            chk(d == pat(a, 0) && oe, "R6 read", d, pat(a, 0));
        end

        // R3: sweep of all lane masks
        for (int m = 0; m < 16; m++) begin
            wr_word(40 + m, pat(40 + m, 1), 1'b0, 1'b1, 4'hF, oe);
            wr_word(40 + m, pat(40 + m, 2), 1'b1, 1'b0, ~4'(m), oe);
            rd_word(40 + m, d, oe);
            exp = merge(pat(40 + m, 1), pat(40 + m, 2), 4'(m));
            chk(d == exp, "R3 lanes", d, exp);
        end
        // R3: lane enables without the qualifier write nothing
        wr_word(40, pat(40, 3), 1'b1, 1'b1, 4'h0, oe);
        rd_word(40, d, oe);
        chk(d == pat(40, 1), "R3 unqualified", d, pat(40, 1));
        // R4: global write overrides lane inputs
        wr_word(41, pat(41, 4), 1'b0, 1'b0, 4'hA, oe);
        rd_word(41, d, oe);
        chk(d == pat(41, 4), "R4 global", d, pat(41, 4));

        // R5: processor start with write controls stays a read
        @(negedge clk);
        addr = AW'(5); din = pat(5, 9); strb_p_n = 1'b0; gw_n = 1'b0;
        @(negedge clk);
        idle_pins();
        @(negedge clk);
        chk(dout == pat(5, 0), "R5 read", dout, pat(5, 0));
        rd_word(5, d, oe);
        chk(d == pat(5, 0), "R5 no write", d, pat(5, 0));

        // R7, R8: bursts from every start offset in both orders
        for (int ilv = 0; ilv < 2; ilv++) begin
            for (int s = 0; s < 4; s++) begin
                deselect_now();
                burst_ilv = 1'(ilv);
                @(negedge clk);
                addr = AW'(8 + s); strb_p_n = 1'b0;
                @(negedge clk);
                strb_p_n = 1'b1; adv_n = 1'b0;
                for (int i = 0; i < 4; i++) begin
                    @(negedge clk);
                    exp = pat(8 + (ilv != 0 ? (s ^ i) : ((s + i) % 4)), 0);
                    chk(dout == exp, ilv != 0 ? "R8 interleaved" : "R7 linear", dout, exp);
                end
                adv_n = 1'b1;
            end
        end
        deselect_now();
        burst_ilv = 1'b0;

        // R9: suspend repeats the word, then advance moves on
        @(negedge clk);
        addr = AW'(20); strb_p_n = 1'b0;
        @(negedge clk);
        strb_p_n = 1'b1;
        @(negedge clk);
        chk(dout == pat(20, 0), "R9 first", dout, pat(20, 0));
        @(negedge clk);
        chk(dout == pat(20, 0), "R9 hold", dout, pat(20, 0));
        adv_n = 1'b0;
        @(negedge clk);
        adv_n = 1'b1;
        chk(dout == pat(20, 0), "R9 hold2", dout, pat(20, 0));
        @(negedge clk);
        chk(dout == pat(21, 0), "R9 advance", dout, pat(21, 0));

        // R7: burst write with wrap from offset 2
        @(negedge clk);
        addr = AW'(26); strb_c_n = 1'b0; gw_n = 1'b0; din = pat(26, 5);
        @(negedge clk);
        strb_c_n = 1'b1; adv_n = 1'b0; din = pat(27, 5);
        @(negedge clk);
        din = pat(24, 5);
        @(negedge clk);
        din = pat(25, 5);
        @(negedge clk);
        idle_pins();
        for (int a = 24; a < 28; a++) begin
            rd_word(a, d, oe);
            chk(d == pat(a, 5), "R7 burst write", d, pat(a, 5));
        end

        // R5: processor strobe ignored while ce1_n is high
        @(negedge clk);
        addr = AW'(12); strb_p_n = 1'b0;
        @(negedge clk);
        strb_p_n = 1'b1;
        @(negedge clk);
        chk(dout == pat(12, 0), "R5 start", dout, pat(12, 0));
        strb_p_n = 1'b0; ce1_n = 1'b1; adv_n = 1'b0; addr = AW'(50);
        @(negedge clk);
        idle_pins();
        chk(dout == pat(12, 0) && dout_oe, "R5 still", dout, pat(12, 0));
        @(negedge clk);
        chk(dout == pat(13, 0) && dout_oe, "R5 ignored", dout, pat(13, 0));

        // R10, R2: double-cycle deselect (variants by each chip enable)
        for (int v = 0; v < 3; v++) begin
            @(negedge clk);
            addr = AW'(30 + v); strb_p_n = 1'b0;
            @(negedge clk);
            strb_p_n = 1'b1; strb_c_n = 1'b0;
            if (v == 0) ce2 = 1'b0;
            else if (v == 1) ce3_n = 1'b1;
            else ce1_n = 1'b1;
            @(negedge clk);
            idle_pins(); adv_n = 1'b0;
            chk(dout == pat(30 + v, 0) && dout_oe, "R6 before deselect", dout, pat(30 + v, 0));
            @(negedge clk);
            chk(dout == pat(30 + v, 0) && dout_oe, "R10 extra cycle", dout, pat(30 + v, 0));
            @(negedge clk);
            chk(dout_oe == 1'b0, "R10 off", 36'(dout_oe), 36'd0);
            @(negedge clk);
            @(negedge clk);
            adv_n = 1'b1;
            chk(dout_oe == 1'b0 && dout == pat(30 + v, 0), "R2 stays deselected", dout, pat(30 + v, 0));
        end

        // R11: output enable acts without a clock
        @(negedge clk);
        addr = AW'(33); strb_p_n = 1'b0;
        @(negedge clk);
        strb_p_n = 1'b1;
        @(negedge clk);
        #1 oe_n = 1'b1;
        #1 chk(dout_oe == 1'b0, "R11 off", 36'(dout_oe), 36'd0);
        oe_n = 1'b0;
        #1 chk(dout_oe == 1'b1, "R11 on", 36'(dout_oe), 36'd1);
        deselect_now();

        repeat (4) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule